// File: doc/BRIEF.md
# Bit-Permute Shift Accumulator

This unit assembles an arbitrary rearrangement of a data word, six bits per issued operation. It keeps a three-part accumulator: an extension register of parameterised width, a 32-bit middle word and a 32-bit low word. Each accepted operation shifts the whole accumulator left by six places. It then fills the six vacated low bits with bits taken from a 32-bit data operand. A 32-bit selector operand holds six 5-bit indices, one for each new bit. After enough issues, the accumulator holds any chosen permutation of the source bits.

An operation is accepted when the issue strobe is high and the instruction word matches the fixed encoding of this operation. A direct write port loads all three registers at once, which is how the accumulator is initialised. Three read ports show the registers at all times. The operation never signals an overflow or an exception. Bits that leave the top of the extension register are lost.

Top module: `perm_shift_acc`

## Requirements
- R1: When `rst_n` is sampled low at a rising clock edge, the extension, middle and low registers all become zero.
- R2: An operation is accepted only when `issue_valid` is high and `instr_word` has bits [31:26]=011100, bits [15:11]=00000, bits [10:6]=10010 and bits [5:0]=000001. Bits [25:21] and [20:16] are don't-care. In any other case, with no write, all registers hold their values.
- R3: An accepted operation sets middle to {middle[25:0], low[31:26]} and extension to {extension[EXT_W-7:0], middle[31:26]}.
- R4: An accepted operation sets low to {low[25:0], b5..b0}. Each bk is `data_opnd` at the index in `sel_opnd[5k+4:5k]`, so bk is taken from bits [4:0] when k=0 and from bits [29:25] when k=5.
- R5: Selector bits [31:30] have no effect on the result.
- R6: When `wr_en` is high, the next register values equal `wr_ext`, `wr_mid` and `wr_low`, even if an operation is accepted in the same cycle.
- R7: The `rd_*` ports show the register contents with no added delay. A new value appears one clock edge after the cycle that causes it.
- R8: Six accepted operations after a clear leave the 36 bits {middle[3:0], low} equal to the six selected groups in issue order, with the first group in the top bits.
- R9: The extension bits shifted out at the top are discarded: with EXT_W=8, an extension of 8'hFF and a middle of zero become 8'hC0 after one operation.
- R10: No operand value stops the operation from completing or alters its width behaviour. All 32 index values select the matching data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Operation request strobe |
| instr_word | input | 32 | Instruction word to decode |
| data_opnd | input | 32 | Source word the bits are taken from |
| sel_opnd | input | 32 | Six packed 5-bit bit indices |
| wr_en | input | 1 | Direct load of all registers |
| wr_ext | input | EXT_W | Load value, extension register |
| wr_mid | input | 32 | Load value, middle register |
| wr_low | input | 32 | Load value, low register |
| rd_ext | output | EXT_W | Extension register contents |
| rd_mid | output | 32 | Middle register contents |
| rd_low | output | 32 | Low register contents |

## Verification
The bench builds the unit with its default extension width of 8. This is wider than one six-bit group, so the wide branch of the extension shift is the one exercised. With an 8-bit extension, a preload of all ones shows the discard at the top after one operation. Eleven operations carry assembled bits into the extension. Widths of six or less take the narrow branch, and this bench does not build it.

// File: rtl/perm_shift_pkg.sv
// Package: shared constants for the bit-permute shift accumulator.
// Assumes a 32-bit word and the fixed instruction field layout 6/5/5/5/5/6.
package perm_shift_pkg;
    localparam int WORD_W  = 32;
    localparam int GROUP_W = 6;
    localparam int IDX_W   = $clog2(WORD_W);

    localparam logic [5:0] OPC_MAJOR = 6'b011100;
    localparam logic [4:0] OPC_RDZ   = 5'b00000;
    localparam logic [4:0] OPC_SHAMT = 5'b10010;
    localparam logic [5:0] OPC_FUNC  = 6'b000001;

    typedef struct packed {
        logic [5:0] major;
        logic [4:0] src_a;
        logic [4:0] src_b;
        logic [4:0] dst;
        logic [4:0] shamt;
        logic [5:0] func;
    } instr_fields_t;
endpackage

// File: rtl/psa_decode.sv
// Module: psa_decode
// Decides whether the instruction word requests the permute-shift operation.
// Assumes the instruction is valid for the whole cycle when issue is high.
// The register-number fields do not take part in the match.
module psa_decode
    import perm_shift_pkg::*;
(
    input  logic        issue,
    input  logic [31:0] instr,
    output logic        go
);
    instr_fields_t f;
    logic          unused_regs;

    assign f           = instr_fields_t'(instr);
    assign unused_regs = ^{f.src_a, f.src_b};

    // Purpose: match every fixed field and qualify the result with the strobe.
    always_comb begin
        go = issue
          && (f.major == OPC_MAJOR)
          && (f.dst   == OPC_RDZ)
          && (f.shamt == OPC_SHAMT)
          && (f.func  == OPC_FUNC);
    end
endmodule

// File: rtl/psa_bit_pick.sv
// Module: psa_bit_pick
// Picks GROUP bits out of the data word. Bit k of the result comes from the
// data bit whose index is held in selector field k (IDX bits, packed from 0).
// Assumes GROUP*IDX <= W. Selector bits above the packed fields are ignored.
module psa_bit_pick #(
    parameter int W     = 32,
    parameter int GROUP = 6,
    parameter int IDX   = $clog2(W)
) (
    input  logic [W-1:0]     data,
    input  logic [W-1:0]     sel,
    output logic [GROUP-1:0] bits
);
    localparam int USED = GROUP * IDX;

    generate
        for (genvar k = 0; k < GROUP; k++) begin : g_pick
            logic [IDX-1:0] idx;
            assign idx     = sel[k*IDX +: IDX];
            // Purpose: one index-driven multiplexer per result bit.
            assign bits[k] = data[idx];
        end
        if (USED < W) begin : g_spare
            logic unused_sel_hi;
            assign unused_sel_hi = ^sel[W-1:USED];
        end
    endgenerate
endmodule

// File: rtl/psa_acc_regs.sv
// Module: psa_acc_regs
// Holds the extension, middle and low accumulator registers.
// On a step, the whole accumulator shifts left by GROUP and new_bits go in
// at the bottom. A direct load beats a step. The reset is synchronous and
// active low. Assumes GROUP < W.
module psa_acc_regs #(
    parameter int W     = 32,
    parameter int EXT_W = 8,
    parameter int GROUP = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [GROUP-1:0] new_bits,
    input  logic             load,
    input  logic [EXT_W-1:0] ld_ext,
    input  logic [W-1:0]     ld_mid,
    input  logic [W-1:0]     ld_low,
    output logic [EXT_W-1:0] q_ext,
    output logic [W-1:0]     q_mid,
    output logic [W-1:0]     q_low
);
    logic [EXT_W-1:0] ext_shift;
    logic [W-1:0]     mid_shift;
    logic [W-1:0]     low_shift;

    // Purpose: shifted middle and low words for one step.
    always_comb begin
        mid_shift = {q_mid[W-GROUP-1:0], q_low[W-1:W-GROUP]};
        low_shift = {q_low[W-GROUP-1:0], new_bits};
    end

    generate
        if (EXT_W > GROUP) begin : g_ext_wide
            logic unused_ext_top;
            assign unused_ext_top = ^q_ext[EXT_W-1:EXT_W-GROUP];
            // Purpose: keep the low extension bits and append the middle top.
            assign ext_shift = {q_ext[EXT_W-GROUP-1:0], q_mid[W-1:W-GROUP]};
        end else begin : g_ext_narrow
            logic unused_ext_all;
            assign unused_ext_all = ^q_ext;
            // Purpose: a narrow extension keeps only the low part of the group.
            assign ext_shift = q_mid[W-GROUP+EXT_W-1:W-GROUP];
        end
    endgenerate

    // Purpose: register update with reset, then load, then step priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_ext <= '0;
            q_mid <= '0;
            q_low <= '0;
        end else if (load) begin
            q_ext <= ld_ext;
            q_mid <= ld_mid;
            q_low <= ld_low;
        end else if (step) begin
            q_ext <= ext_shift;
            q_mid <= mid_shift;
            q_low <= low_shift;
        end
    end
endmodule

// File: rtl/perm_shift_acc.sv
// Module: perm_shift_acc (top)
// Bit-permute shift accumulator: decodes the request, picks six bits from
// the data operand, and shifts them into the three-part accumulator.
// Assumes a 32-bit datapath. Register-file access and hazards are handled
// outside this block.
module perm_shift_acc
    import perm_shift_pkg::*;
#(
    parameter int EXT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [31:0]      instr_word,
    input  logic [31:0]      data_opnd,
    input  logic [31:0]      sel_opnd,
    input  logic             wr_en,
    input  logic [EXT_W-1:0] wr_ext,
    input  logic [31:0]      wr_mid,
    input  logic [31:0]      wr_low,
    output logic [EXT_W-1:0] rd_ext,
    output logic [31:0]      rd_mid,
    output logic [31:0]      rd_low
);
    logic               go;
    logic [GROUP_W-1:0] picked;

    psa_decode u_dec (
        .issue (issue_valid),
        .instr (instr_word),
        .go    (go)
    );

    psa_bit_pick #(.W(WORD_W), .GROUP(GROUP_W), .IDX(IDX_W)) u_pick (
        .data (data_opnd),
        .sel  (sel_opnd),
        .bits (picked)
    );

    psa_acc_regs #(.W(WORD_W), .EXT_W(EXT_W), .GROUP(GROUP_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (go),
        .new_bits (picked),
        .load     (wr_en),
        .ld_ext   (wr_ext),
        .ld_mid   (wr_mid),
        .ld_low   (wr_low),
        .q_ext    (rd_ext),
        .q_mid    (rd_mid),
        .q_low    (rd_low)
    );
endmodule

// File: rtl/perm_shift_acc_chk.sv
// Module: perm_shift_acc_chk
// Temporal checks on the accumulator, attached to every perm_shift_acc by bind.
// Assumes EXT_W > 6, which is the default build.
module perm_shift_acc_chk #(
    parameter int EXT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_valid,
    input logic [31:0]      instr_word,
    input logic [31:0]      data_opnd,
    input logic [31:0]      sel_opnd,
    input logic             wr_en,
    input logic [EXT_W-1:0] wr_ext,
    input logic [31:0]      wr_mid,
    input logic [31:0]      wr_low,
    input logic [EXT_W-1:0] rd_ext,
    input logic [31:0]      rd_mid,
    input logic [31:0]      rd_low
);
    logic req;
    assign req = issue_valid && instr_word[31:26] == 6'b011100
              && instr_word[15:0] == {5'b00000, 5'b10010, 6'b000001};

    // R1: reset empties the accumulator
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_ext == '0 && rd_mid == '0 && rd_low == '0));

    // R2: no request and no write leaves the accumulator unchanged
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !req) |=> ($stable(rd_ext) && $stable(rd_mid) && $stable(rd_low)));

    // R3: the middle word takes in the top group of the low word
    p_mid_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr_en) |=> rd_mid == {$past(rd_mid[25:0]), $past(rd_low[31:26])});

    // R3: the extension takes in the top group of the middle word
    p_ext_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr_en) |=> rd_ext[5:0] == $past(rd_mid[31:26]));

    // R4: low bit 0 follows the index held in the lowest selector field
    p_pick0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr_en) |=> rd_low[0] == $past(data_opnd[sel_opnd[4:0]]));

    // R4: low bit 5 follows the index held in the highest selector field
    p_pick5_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr_en) |=> rd_low[5] == $past(data_opnd[sel_opnd[29:25]]));

    // R6: a direct write wins over a request in the same cycle
    p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_ext == $past(wr_ext) && rd_mid == $past(wr_mid)
                   && rd_low == $past(wr_low)));
endmodule

bind perm_shift_acc perm_shift_acc_chk #(.EXT_W(EXT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .instr_word  (instr_word),
    .data_opnd   (data_opnd),
    .sel_opnd    (sel_opnd),
    .wr_en       (wr_en),
    .wr_ext      (wr_ext),
    .wr_mid      (wr_mid),
    .wr_low      (wr_low),
    .rd_ext      (rd_ext),
    .rd_mid      (rd_mid),
    .rd_low      (rd_low)
);

// File: tb/perm_shift_acc_tb.sv
// Directed bench for perm_shift_acc. One task per scenario, each checking its
// own results against a model written from the requirements.
module perm_shift_acc_tb;
    localparam int EW = 8;
    localparam logic [31:0] GOOD = {6'b011100, 5'd3, 5'd7, 5'd0, 5'b10010, 6'b000001};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [31:0]   instr_word = '0;
    logic [31:0]   data_opnd = '0;
    logic [31:0]   sel_opnd = '0;
    logic          wr_en = 1'b0;
    logic [EW-1:0] wr_ext = '0;
    logic [31:0]   wr_mid = '0;
    logic [31:0]   wr_low = '0;
    logic [EW-1:0] rd_ext;
    logic [31:0]   rd_mid;
    logic [31:0]   rd_low;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [EW-1:0] m_ext;
    logic [31:0]   m_mid, m_low;

    always #10 clk = ~clk;

    perm_shift_acc #(.EXT_W(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr_word(instr_word),
        .data_opnd(data_opnd), .sel_opnd(sel_opnd), .wr_en(wr_en), .wr_ext(wr_ext),
        .wr_mid(wr_mid), .wr_low(wr_low), .rd_ext(rd_ext), .rd_mid(rd_mid), .rd_low(rd_low)
    );

    function automatic logic [31:0] mk_sel(input logic [4:0] i5, i4, i3, i2, i1, i0);
        return {2'b00, i5, i4, i3, i2, i1, i0};
    endfunction

    function automatic logic [5:0] group_of(input logic [31:0] d, input logic [31:0] s);
        logic [5:0] g;
        for (int k = 0; k < 6; k++) g[k] = d[s[k*5 +: 5]];
        return g;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check({tag, " ext"}, 64'(rd_ext), 64'(m_ext));
        check({tag, " mid"}, 64'(rd_mid), 64'(m_mid));
        check({tag, " low"}, 64'(rd_low), 64'(m_low));
    endtask

    // One cycle of stimulus: driven at a falling edge, results sampled at the next.
    task automatic cycle(input logic v, input logic [31:0] ins, input logic [31:0] d,
                         input logic [31:0] s);
        @(negedge clk);
        issue_valid = v; instr_word = ins; data_opnd = d; sel_opnd = s;
        if (v && ins[31:26] == 6'b011100 && ins[15:0] == 16'h0481) begin
            m_ext = {m_ext[EW-7:0], m_mid[31:26]};
            m_mid = {m_mid[25:0], m_low[31:26]};
            m_low = {m_low[25:0], group_of(d, s)};
        end
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic load(input logic [EW-1:0] e, input logic [31:0] m, input logic [31:0] l);
        @(negedge clk);
        wr_en = 1'b1; wr_ext = e; wr_mid = m; wr_low = l;
        @(negedge clk);
        wr_en = 1'b0;
        m_ext = e; m_mid = m; m_low = l;
    endtask

    task automatic t_reset;
        load(8'h5A, 32'h1234_5678, 32'h9ABC_DEF0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_ext = '0; m_mid = '0; m_low = '0;
        check_state("R1 reset");
    endtask

    task automatic t_decode;
        logic [31:0] bad;
        load(8'h3C, 32'hDEAD_BEEF, 32'hCAFE_F00D);
        bad = GOOD; bad[31:26] = 6'b011101;  cycle(1'b1, bad, 32'hFFFF_FFFF, '0);
        check_state("R2 bad major");
        bad = GOOD; bad[15:11] = 5'd1;       cycle(1'b1, bad, 32'hFFFF_FFFF, '0);
        check_state("R2 nonzero dst");
        bad = GOOD; bad[10:6] = 5'b10011;    cycle(1'b1, bad, 32'hFFFF_FFFF, '0);
        check_state("R2 bad shamt");
        bad = GOOD; bad[5:0] = 6'b000000;    cycle(1'b1, bad, 32'hFFFF_FFFF, '0);
        check_state("R2 bad func");
        cycle(1'b0, GOOD, 32'hFFFF_FFFF, '0);
        check_state("R2 no strobe");
        bad = GOOD; bad[25:16] = 10'h3FF;    cycle(1'b1, bad, 32'hFFFF_FFFF, '0);
        check_state("R2 reg fields ignored");
    endtask

    task automatic t_shift;
        load(8'h81, 32'hF0F0_0F0F, 32'hA55A_C33C);
        cycle(1'b1, GOOD, 32'h0, '0);
        check_state("R3 shift");
        check("R3 mid exact", 64'(rd_mid), 64'h3C03_C3E9);
    endtask

    task automatic t_pick;
        logic [31:0] d = 32'h8000_0001;
        load('0, '0, '0);
        cycle(1'b1, GOOD, d, mk_sel(5'd31, 5'd0, 5'd1, 5'd31, 5'd2, 5'd0));
        check("R4 pick exact", 64'(rd_low), 64'(6'b110101));
        check_state("R4 pick");
        for (int i = 0; i < 32; i++) begin
            load('0, '0, '0);
            cycle(1'b1, GOOD, 32'(1) << i, mk_sel(5'(i), 5'(i), 5'd0, 5'd0, 5'd0, 5'(i)));
            check($sformatf("R10 index %0d", i), 64'(rd_low[5]), 64'(1));
            check($sformatf("R10 index %0d low", i), 64'(rd_low[0]), 64'(1));
        end
    endtask

    task automatic t_reserved;
        logic [31:0] s = mk_sel(5'd4, 5'd9, 5'd17, 5'd22, 5'd30, 5'd1);
        load(8'h11, 32'h2222_3333, 32'h4444_5555);
        cycle(1'b1, GOOD, 32'h6B3D_19E7, s | 32'hC000_0000);
        check_state("R5 reserved set");
        check("R5 same as clear", 64'(rd_low[5:0]), 64'(group_of(32'h6B3D_19E7, s)));
    endtask

    task automatic t_write_pri;
        load(8'h77, 32'h1111_1111, 32'h2222_2222);
        @(negedge clk);
        wr_en = 1'b1; wr_ext = 8'hA3; wr_mid = 32'h0BAD_CAFE; wr_low = 32'h0123_4567;
        issue_valid = 1'b1; instr_word = GOOD; data_opnd = 32'hFFFF_FFFF; sel_opnd = '0;
        @(negedge clk);
        wr_en = 1'b0; issue_valid = 1'b0;
        m_ext = 8'hA3; m_mid = 32'h0BAD_CAFE; m_low = 32'h0123_4567;
        check_state("R6 write wins");
    endtask

    task automatic t_latency;
        load('0, '0, 32'hFC00_0000);
        @(negedge clk);
        issue_valid = 1'b1; instr_word = GOOD; data_opnd = '0; sel_opnd = '0;
        check("R7 no change before edge", 64'(rd_mid), 64'(0));
        @(negedge clk);
        issue_valid = 1'b0;
        check("R7 visible after edge", 64'(rd_mid), 64'h3F);
    endtask

    task automatic t_assemble;
        logic [31:0] d = 32'hC96E_25B1;
        logic [35:0] exp36 = '0;
        load('0, '0, '0);
        for (int n = 0; n < 6; n++) begin
            logic [31:0] s = mk_sel(5'(n*5+1), 5'(31-n), 5'(n*3), 5'(n+7), 5'(29-2*n), 5'(n*4));
            exp36 = {exp36[29:0], group_of(d, s)};
            cycle(1'b1, GOOD, d, s);
        end
        check("R8 36-bit assembly", 64'({rd_mid[3:0], rd_low}), 64'(exp36));
        check_state("R8 state");
        for (int n = 0; n < 5; n++) cycle(1'b1, GOOD, d, mk_sel(5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6));
        check("R8 reaches extension", 64'(rd_ext[1:0]), 64'(exp36[35:34]));
        check_state("R8 after eleven");
    endtask

    task automatic t_discard;
        load(8'hFF, '0, '0);
        cycle(1'b1, GOOD, '0, '0);
        check("R9 top discarded", 64'(rd_ext), 64'hC0);
        check_state("R9 state");
    endtask

    initial begin
        m_ext = '0; m_mid = '0; m_low = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_state("R1 initial");
        t_reset();
        t_decode();
        t_shift();
        t_pick();
        t_reserved();
        t_write_pri();
        t_latency();
        t_assemble();
        t_discard();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule